// File: doc/BRIEF.md
# Memory-Card Slot Status and Insertion Interrupt Block

This block sits beside a memory-card controller and gives software a small word-addressed register window onto the card slot. It carries two things. The first is a live view of the write-protect switch. The second is a sticky record that a card was inserted, which also drives an interrupt line. Software reads the status word to learn why the interrupt fired. It writes a one to the insertion bit to acknowledge the event, which drops the interrupt.

The insertion record is a two-state machine. `ST_CLEAR` means no event is pending. `ST_PENDING` means an insertion was seen and has not been acknowledged. Three transitions are defined:
- `T_SET` (ST_CLEAR to ST_PENDING) is taken when the insert input is high.
- `T_ACK` (ST_PENDING to ST_CLEAR) is taken on an acknowledge write while the insert input is low.
- `T_HOLD` (ST_PENDING to ST_PENDING) is taken otherwise, which includes an acknowledge that coincides with a new insertion.

The interrupt output is high exactly while the machine is in `ST_PENDING`.

The block also answers at a fixed identification index and at a constant index. Every response is registered. It appears in the cycle after the request is sampled, and an illegal access raises a one-cycle error strobe.

Top module: `cardslot_stat_regs`

## Requirements
- R1: While and right after reset, `irq_o`, `rsp_err` and `rsp_rdata` are all zero and no insertion is pending.
- R2: A read is answered in the cycle after it is sampled. Index 0 returns 0x41034003, index 1 returns 0 and index 3 returns 0x00000011. In any cycle that follows no read, `rsp_rdata` is 0.
- R3: A read of index 2 returns, in bit 0, the level of `wp_lvl_i` at the edge where the read is sampled.
- R4: `ins_evt_i` high at an edge sets the pending state, and `irq_o` is high from the next cycle. It stays high after `ins_evt_i` falls until it is acknowledged.
- R5: A write to index 2 whose data bit 3 is one clears the pending state, and `irq_o` is low from the next cycle. A write to index 2 with data bit 3 at zero changes nothing.
- R6: When an acknowledge write and a high `ins_evt_i` meet at the same edge, the pending state stays set.
- R7: In a read of index 2, every bit other than bits 0 and 3 is zero. The written data cannot change bit 0.
- R8: Writes to indices 1 and 3 are accepted with no error and have no effect on the pending state or `irq_o`.
- R9: A read or write to any index of 4 or above, or a write to index 0, pulses `rsp_err` high for the one following cycle. In that cycle `rsp_rdata` is 0.
- R10: Bit 3 of an index 2 read equals the `irq_o` level in the cycle the read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Word index of the access |
| req_wdata | input | 32 | Write data |
| wp_lvl_i | input | 1 | Write-protect switch level from the card controller |
| ins_evt_i | input | 1 | Card-insert indication from the card controller |
| rsp_rdata | output | 32 | Read data, registered; zero when no read was sampled |
| rsp_err | output | 1 | One-cycle strobe for an illegal access |
| irq_o | output | 1 | Insertion interrupt, high while an event is pending |

## Verification
Every index of the full index space is read with the write-protect level alternating. This separates the decode of the four legal words from the error region, and shows that bit 0 follows the input rather than stored state. Acknowledge writes are swept over all sixteen low-nibble patterns. This shows that only bit 3 clears the event and that no pattern reaches bit 0 or the reserved bits. Writes to every index are made while an event is pending. They show that only an index 2 write with bit 3 set can clear it, and that the ignored indices raise no error. Directed sequences cover an insertion followed by the input falling, and an acknowledge in the same cycle as an insertion, from each of the two states.

// File: rtl/cardslot_pkg.sv
package cardslot_pkg;

    // Register word selected by the low two index bits.
    typedef enum logic [1:0] {
        SEL_IDENT = 2'd0,
        SEL_NULL  = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_CONST = 2'd3
    } cs_sel_e;

    // Insertion event tracker.
    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_PENDING = 1'b1
    } cs_ins_state_e;

    // Bit positions inside the status word; software decodes these.
    localparam int unsigned WP_POS  = 0;
    localparam int unsigned INS_POS = 3;

endpackage

// File: rtl/cardslot_addr_dec.sv
module cardslot_addr_dec
    import cardslot_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    output cs_sel_e           sel_o,
    output logic              rd_en_o,
    output logic              ack_o,
    output logic              bad_o
);

    localparam logic [DATA_W-1:0] INS_MASK = DATA_W'(1) << INS_POS;

    logic in_window;
    logic wr_stat;

    always_comb begin
        in_window = (req_idx >> 2) == '0;
        sel_o     = cs_sel_e'(req_idx[1:0]);
        rd_en_o   = req_valid && !req_write && in_window;
        wr_stat   = req_valid && req_write && in_window && (sel_o == SEL_STAT);
        ack_o     = wr_stat && ((req_wdata & INS_MASK) != '0);
        // Outside the window, or a write to the read-only identity word.
        bad_o     = req_valid && (!in_window || (req_write && sel_o == SEL_IDENT));
    end

endmodule

// File: rtl/cardslot_ins_fsm.sv
module cardslot_ins_fsm
    import cardslot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_i,
    input  logic ack_i,
    output logic pend_o
);

    cs_ins_state_e state_q;
    cs_ins_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (ins_i) begin
                    state_d = ST_PENDING;          // T_SET
                end
            end
            ST_PENDING: begin
                if (ack_i && !ins_i) begin
                    state_d = ST_CLEAR;            // T_ACK
                end                                // else T_HOLD
            end
        endcase
    end

    always_comb begin
        pend_o = (state_q == ST_PENDING);
    end

endmodule

// File: rtl/cardslot_rsp.sv
module cardslot_rsp
    import cardslot_pkg::*;
#(
    parameter int unsigned       DATA_W    = 32,
    parameter logic [DATA_W-1:0] ID_WORD   = 32'h4103_4003,
    parameter logic [DATA_W-1:0] CONST_WORD = 32'h0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cs_sel_e           sel_i,
    input  logic              rd_en_i,
    input  logic              bad_i,
    input  logic              wp_i,
    input  logic              pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] word_d;

    always_comb begin
        stat_word          = '0;
        stat_word[WP_POS]  = wp_i;
        stat_word[INS_POS] = pend_i;
        unique case (sel_i)
            SEL_IDENT: word_d = ID_WORD;
            SEL_NULL:  word_d = '0;
            SEL_STAT:  word_d = stat_word;
            SEL_CONST: word_d = CONST_WORD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            rdata_o <= rd_en_i ? word_d : '0;
            err_o   <= bad_i;
        end
    end

endmodule

// File: rtl/cardslot_stat_regs.sv
module cardslot_stat_regs
    import cardslot_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter logic [31:0] ID_WORD    = 32'h4103_4003,
    parameter logic [31:0] CONST_WORD = 32'h0000_0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [31:0]      req_wdata,
    input  logic             wp_lvl_i,
    input  logic             ins_evt_i,
    output logic [31:0]      rsp_rdata,
    output logic             rsp_err,
    output logic             irq_o
);

    localparam int unsigned DATA_W = 32;

    cs_sel_e sel;
    logic    rd_en;
    logic    ack;
    logic    bad;
    logic    pend;

    cardslot_addr_dec #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .sel_o     (sel),
        .rd_en_o   (rd_en),
        .ack_o     (ack),
        .bad_o     (bad)
    );

    cardslot_ins_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ins_i  (ins_evt_i),
        .ack_i  (ack),
        .pend_o (pend)
    );

    cardslot_rsp #(
        .DATA_W     (DATA_W),
        .ID_WORD    (ID_WORD),
        .CONST_WORD (CONST_WORD)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .rd_en_i (rd_en),
        .bad_i   (bad),
        .wp_i    (wp_lvl_i),
        .pend_i  (pend),
        .rdata_o (rsp_rdata),
        .err_o   (rsp_err)
    );

    assign irq_o = pend;

endmodule

// File: rtl/cardslot_stat_chk.sv
module cardslot_stat_chk #(
    parameter int unsigned IDX_W   = 8,
    parameter logic [31:0] ID_WORD = 32'h4103_4003
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [IDX_W-1:0] req_idx,
    input logic [31:0]      req_wdata,
    input logic             wp_lvl_i,
    input logic             ins_evt_i,
    input logic [31:0]      rsp_rdata,
    input logic             rsp_err,
    input logic             irq_o
);

    logic in_win;
    logic stat_rd;
    logic id_rd;
    logic clr_wr;
    logic bad_acc;

    assign in_win  = (req_idx >> 2) == '0;
    assign stat_rd = req_valid && !req_write && in_win && (req_idx[1:0] == 2'd2);
    assign id_rd   = req_valid && !req_write && in_win && (req_idx[1:0] == 2'd0);
    assign clr_wr  = req_valid && req_write && in_win && (req_idx[1:0] == 2'd2)
                     && ((req_wdata & 32'h0000_0008) != 32'h0);
    assign bad_acc = req_valid && (!in_win || (req_write && req_idx[1:0] == 2'd0));

    AST_IDENT_READ:  assert property (@(posedge clk) disable iff (!rst_n) id_rd |=> rsp_rdata == ID_WORD); // R2
    AST_WP_LIVE:     assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> rsp_rdata[0] == $past(wp_lvl_i)); // R3
    AST_INS_SETS:    assert property (@(posedge clk) disable iff (!rst_n) ins_evt_i |=> irq_o); // R4
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_o && !clr_wr) |=> irq_o); // R4
    AST_ACK_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !ins_evt_i) |=> !irq_o); // R5
    AST_SET_WINS:    assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && ins_evt_i) |=> irq_o); // R6
    AST_RSV_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> (rsp_rdata & 32'hFFFF_FFF6) == 32'h0); // R7
    AST_NO_ERR:      assert property (@(posedge clk) disable iff (!rst_n) !bad_acc |=> !rsp_err); // R8
    AST_ERR_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) bad_acc |=> (rsp_err && rsp_rdata == 32'h0)); // R9
    AST_STAT_IRQ:    assert property (@(posedge clk) disable iff (!rst_n) stat_rd |=> rsp_rdata[3] == $past(irq_o)); // R10

endmodule

bind cardslot_stat_regs cardslot_stat_chk #(
    .IDX_W   (IDX_W),
    .ID_WORD (ID_WORD)
) u_chk (.*);

// File: tb/cardslot_stat_regs_tb_top.sv
module cardslot_stat_regs_tb_top;

    localparam int IDX_W = 8;
    localparam int NIDX  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic             req_write;
    logic [IDX_W-1:0] req_idx;
    logic [31:0]      req_wdata;
    logic             wp_lvl_i;
    logic             ins_evt_i;
    logic [31:0]      rsp_rdata;
    logic             rsp_err;
    logic             irq_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic exp_pend = 1'b0;
    logic [31:0] exp_rd;
    logic        exp_err;

    always #5 clk = ~clk;

    cardslot_stat_regs #(.IDX_W(IDX_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .wp_lvl_i  (wp_lvl_i),
        .ins_evt_i (ins_evt_i),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq_o     (irq_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(int idx, logic wp, logic pend);
        case (idx)
            0:       return 32'h4103_4003;
            1:       return 32'h0;
            2:       return {28'h0, pend, 2'b00, wp};
            3:       return 32'h0000_0011;
            default: return 32'h0;
        endcase
    endfunction

    // Drive one cycle just after a falling edge; return at the next falling edge.
    task automatic step(logic v, logic w, int idx, logic [31:0] wd, logic ins, logic wp);
        req_valid = v;
        req_write = w;
        req_idx   = IDX_W'(idx);
        req_wdata = wd;
        ins_evt_i = ins;
        wp_lvl_i  = wp;
        exp_rd  = (v && !w && idx < 4) ? model_word(idx, wp, exp_pend) : 32'h0;
        exp_err = v && (idx >= 4 || (w && idx == 0));
        if (ins) exp_pend = 1'b1;
        else if (v && w && idx == 2 && wd[3]) exp_pend = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        chk({tag, " rdata"}, rsp_rdata, exp_rd);
        chk({tag, " err"}, {31'h0, rsp_err}, {31'h0, exp_err});
        chk({tag, " irq"}, {31'h0, irq_o}, {31'h0, exp_pend});
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_idx = '0; req_wdata = '0;
        wp_lvl_i = 1'b1; ins_evt_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds everything low even with inputs active
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 err", {31'h0, rsp_err}, 32'h0);
        chk("R1 rdata", rsp_rdata, 32'h0);
        ins_evt_i = 1'b0;
        rst_n = 1'b1;
        idle();
        check_all("R1");

        // Read sweep over the full index space, write-protect alternating
        for (int i = 0; i < NIDX; i++) begin
            step(1'b1, 1'b0, i, 32'h0, 1'b0, i[0]);
            if (i == 2)     check_all("R3");
            else if (i < 4) check_all("R2");
            else            check_all("R9");
        end
        idle();
        check_all("R2 idle");

        // Insertion then input falls: sticky
        step(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
        check_all("R4 set");
        repeat (3) begin
            idle();
            check_all("R4 hold");
        end
        step(1'b1, 1'b0, 2, 32'h0, 1'b0, 1'b1);
        check_all("R10");
        step(1'b1, 1'b0, 2, 32'h0, 1'b0, 1'b0);
        check_all("R10");

        // Acknowledge pattern sweep
        for (int n = 0; n < 16; n++) begin
            step(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
            step(1'b1, 1'b1, 2, {28'h5A5A5A5, 4'(n)}, 1'b0, 1'b0);
            check_all("R5");
            step(1'b1, 1'b0, 2, 32'h0, 1'b0, n[1]);
            check_all("R7");
        end

        // Same-cycle acknowledge and insertion, from each state
        step(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 2, 32'hFFFF_FFFF, 1'b1, 1'b0);
        check_all("R6 from pending");
        step(1'b1, 1'b1, 2, 32'h8, 1'b0, 1'b0);
        check_all("R5 ack");
        step(1'b1, 1'b1, 2, 32'h8, 1'b1, 1'b0);
        check_all("R6 from clear");

        // Writes to every index while pending
        for (int i = 0; i < NIDX; i++) begin
            step(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
            step(1'b1, 1'b1, i, 32'hFFFF_FFFF, 1'b0, 1'b1);
            if (i == 1 || i == 3) check_all("R8");
            else if (i == 2)      check_all("R5");
            else                  check_all("R9");
        end
        step(1'b1, 1'b0, 2, 32'h0, 1'b0, 1'b1);
        check_all("R7");

        done = 1;
        summary();
        $finish;
    end

endmodule